// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers single-cycle event pulses from three groups of functional units: serial channels, DMA channels and timers. It keeps one sticky status flag per source, masks each flag with its own enable bit, and raises a level request to the host processor while any enabled flag is pending. Software reads and clears the flags through a small register port. Each flag is cleared by writing one to its bit.

When the host answers with its acknowledge strobe, the block can return an 8-bit vector on a driven-when-enabled data bus. Three acknowledge protocols are available: no vector at all, a vector on the first strobe, or a vector only on the second strobe. The vector is either a fully programmable byte, or two programmable upper bits followed by a 6-bit code that names the highest-priority pending source. A control bit lets the DMA group outrank the serial group. The timers always rank last.

Register map (4-bit address): 0 serial status, 1 DMA status, 2 timer status (bits 3:0), 3 serial enable, 4 DMA enable, 5 timer enable, 6 control, 7 fixed vector, 8 modified-vector upper bits (bits 7:6 written; a read returns those bits above the live 6-bit code). Other addresses read as zero.

Top module: `vpic_top`

## Requirements
- R1: Reset clears every status flag, enable bit and control field. A one-cycle pulse on a source input sets its flag, and the flag reads back as 1 at addresses 0, 1 and 2 from the next cycle onward.
- R2: Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. If a source pulse arrives in the same cycle as a clearing write to its bit, the flag stays set.
- R3: Enable registers at addresses 3, 4 and 5 mask the flags bit by bit. `irq` is high exactly when at least one flag is both set and enabled.
- R4: Control bits [1:0] select the acknowledge mode: 00 none, 01 single, 10 double, 11 treated as none. In the none modes `vec_oe` never rises.
- R5: In single mode, a rising edge on `iack` makes `vec_oe` go high from the next cycle. It stays high until the clock edge at which `iack` is sampled low.
- R6: In double mode, the first rising edge of `iack` drives nothing. The second rising edge drives the vector in the same way as R5.
- R7: When control bit 2 is 0, the vector is the byte at address 7. When it is 1, the vector is {address-8 bits 7:6, 6-bit source code}.
- R8: The source code is the flat source index: serial i gives i, DMA i gives 8+i, timer i gives 16+i. It is 63 when no enabled flag is pending.
- R9: By default the serial group outranks DMA, and DMA outranks the timers. Control bit 3 set to 1 puts DMA above serial, and the timers stay lowest. Within a group, the lower index wins.
- R10: The vector is captured at the acknowledge edge that starts output. Flags that change while `vec_oe` is high do not alter `vec_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ser | input | 8 | Serial-channel source pulses |
| src_dma | input | 8 | DMA-channel source pulses |
| src_tmr | input | 4 | Timer source pulses |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request to the host |
| iack | input | 1 | Host acknowledge strobe, active high |
| vec_out | output | 8 | Vector data |
| vec_oe | output | 1 | Vector bus drive enable |

## Verification
Two functions can land in the same clock edge: a source pulse setting a flag and a software write clearing it. The bench provokes this directly by raising a pulse and a write-one-to-clear on the same bit in one cycle, and then during a long random phase. A behavioural model gives the set priority and checks the readback and `irq` on every cycle. A second collision arises when a pulse from a higher-priority source arrives while a vector is being driven. The model captures the vector at the acknowledge edge, so any later change on `vec_out` is reported.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    localparam int CODE_W = 6;
    localparam logic [CODE_W-1:0] CODE_NONE = '1;

    typedef enum logic [1:0] {
        ACK_NONE   = 2'b00,
        ACK_SINGLE = 2'b01,
        ACK_DOUBLE = 2'b10,
        ACK_RSVD   = 2'b11
    } ack_mode_e;

    typedef struct packed {
        logic      dma_first;
        logic      vec_mod;
        ack_mode_e mode;
    } ctrl_t;

    typedef enum logic [3:0] {
        A_ST_SER = 4'd0,
        A_ST_DMA = 4'd1,
        A_ST_TMR = 4'd2,
        A_EN_SER = 4'd3,
        A_EN_DMA = 4'd4,
        A_EN_TMR = 4'd5,
        A_CTRL   = 4'd6,
        A_VEC    = 4'd7,
        A_MVEC   = 4'd8
    } reg_addr_e;

    function automatic logic [CODE_W-1:0] lowest_bit(input logic [31:0] v);
        logic [CODE_W-1:0] r;
        r = CODE_NONE;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = CODE_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/vpic_flag_bank.sv
module vpic_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         wr_clr,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] en,
    output logic [W-1:0] masked
);
    logic [W-1:0] clr_mask;

    assign clr_mask = wr_clr ? wdata : '0;
    assign masked   = stat & en;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            en   <= '0;
        end else begin
            stat <= (stat & ~clr_mask) | set;
            if (wr_en) en <= wdata;
        end
    end

    // R2: a pulse beats a same-cycle clear
    a_r2_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> ((stat & $past(set)) == $past(set)));

    // R2: write-one clears when no pulse collides
    a_r2_w1c: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && set == '0) |=> ((stat & $past(wdata)) == '0));

    // R2: a zero write bit keeps the flag
    a_r2_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr_clr) |=> ((stat & ~$past(wdata)) == ($past(stat) & ~$past(wdata)) | ($past(set) & ~$past(wdata))));
endmodule

// File: rtl/vpic_prio.sv
module vpic_prio
    import vpic_pkg::*;
#(
    parameter int N_SER = 8,
    parameter int N_DMA = 8,
    parameter int N_TMR = 4
) (
    input  logic [N_SER-1:0]  ser_m,
    input  logic [N_DMA-1:0]  dma_m,
    input  logic [N_TMR-1:0]  tmr_m,
    input  logic              dma_first,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] DMA_BASE = CODE_W'(N_SER);
    localparam logic [CODE_W-1:0] TMR_BASE = CODE_W'(N_SER + N_DMA);

    logic [CODE_W-1:0] c_ser, c_dma, c_tmr, c_hi, c_lo;

    always_comb begin
        c_ser = (|ser_m) ? lowest_bit(32'(ser_m)) : CODE_NONE;
        c_dma = (|dma_m) ? lowest_bit(32'(dma_m)) + DMA_BASE : CODE_NONE;
        c_tmr = (|tmr_m) ? lowest_bit(32'(tmr_m)) + TMR_BASE : CODE_NONE;
        c_hi  = dma_first ? c_dma : c_ser;
        c_lo  = dma_first ? c_ser : c_dma;
        if (c_hi != CODE_NONE)      code = c_hi;
        else if (c_lo != CODE_NONE) code = c_lo;
        else                        code = c_tmr;
    end
endmodule

// File: rtl/vpic_ack.sv
module vpic_ack
    import vpic_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iack,
    input  ack_mode_e     mode,
    input  logic [VW-1:0] vec_in,
    output logic          vec_oe,
    output logic [VW-1:0] vec_out
);
    logic iack_q, second_pend, rise;

    assign rise = iack & ~iack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            iack_q      <= 1'b0;
            second_pend <= 1'b0;
            vec_oe      <= 1'b0;
            vec_out     <= '0;
        end else begin
            iack_q <= iack;
            if (!iack) vec_oe <= 1'b0;
            if (rise) begin
                unique case (mode)
                    ACK_SINGLE: begin
                        vec_oe  <= 1'b1;
                        vec_out <= vec_in;
                    end
                    ACK_DOUBLE: begin
                        if (second_pend) begin
                            vec_oe      <= 1'b1;
                            vec_out     <= vec_in;
                            second_pend <= 1'b0;
                        end else begin
                            second_pend <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (mode != ACK_DOUBLE) second_pend <= 1'b0;
        end
    end

    // R4: none modes never start output
    a_r4_none_silent: assert property (@(posedge clk) disable iff (rst)
        (!vec_oe && (mode == ACK_NONE || mode == ACK_RSVD)) |=> !vec_oe);

    // R5: output only while the strobe was held
    a_r5_oe_needs_iack: assert property (@(posedge clk) disable iff (rst)
        vec_oe |-> $past(iack));

    // R10: vector stays frozen while driven
    a_r10_vec_frozen: assert property (@(posedge clk) disable iff (rst)
        (vec_oe && $past(vec_oe)) |-> $stable(vec_out));
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int N_SER = 8,
    parameter int N_DMA = 8,
    parameter int N_TMR = 4,
    parameter int DW    = 8,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SER-1:0] src_ser,
    input  logic [N_DMA-1:0] src_dma,
    input  logic [N_TMR-1:0] src_tmr,
    input  logic [AW-1:0]    reg_addr,
    input  logic             reg_wr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq,
    input  logic             iack,
    output logic [DW-1:0]    vec_out,
    output logic             vec_oe
);
    localparam int HI_W = DW - CODE_W;
    localparam int TMR_BASE = N_SER + N_DMA;

    logic [N_SER-1:0] st_ser, en_ser, m_ser;
    logic [N_DMA-1:0] st_dma, en_dma, m_dma;
    logic [N_TMR-1:0] st_tmr, en_tmr, m_tmr;
    ctrl_t             ctrl;
    logic [DW-1:0]     fixed_vec;
    logic [HI_W-1:0]   mvec_hi;
    logic [CODE_W-1:0] code;
    logic [DW-1:0]     vec_sel;

    function automatic logic hit(input logic [AW-1:0] a, input reg_addr_e r);
        return a == AW'(r);
    endfunction

    vpic_flag_bank #(.W(N_SER)) u_ser (
        .clk(clk), .rst(rst), .set(src_ser),
        .wr_clr(reg_wr && hit(reg_addr, A_ST_SER)),
        .wr_en (reg_wr && hit(reg_addr, A_EN_SER)),
        .wdata(reg_wdata[N_SER-1:0]),
        .stat(st_ser), .en(en_ser), .masked(m_ser)
    );

    vpic_flag_bank #(.W(N_DMA)) u_dma (
        .clk(clk), .rst(rst), .set(src_dma),
        .wr_clr(reg_wr && hit(reg_addr, A_ST_DMA)),
        .wr_en (reg_wr && hit(reg_addr, A_EN_DMA)),
        .wdata(reg_wdata[N_DMA-1:0]),
        .stat(st_dma), .en(en_dma), .masked(m_dma)
    );

    vpic_flag_bank #(.W(N_TMR)) u_tmr (
        .clk(clk), .rst(rst), .set(src_tmr),
        .wr_clr(reg_wr && hit(reg_addr, A_ST_TMR)),
        .wr_en (reg_wr && hit(reg_addr, A_EN_TMR)),
        .wdata(reg_wdata[N_TMR-1:0]),
        .stat(st_tmr), .en(en_tmr), .masked(m_tmr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            fixed_vec <= '0;
            mvec_hi   <= '0;
        end else if (reg_wr) begin
            if (hit(reg_addr, A_CTRL)) ctrl      <= ctrl_t'(reg_wdata[$bits(ctrl_t)-1:0]);
            if (hit(reg_addr, A_VEC))  fixed_vec <= reg_wdata;
            if (hit(reg_addr, A_MVEC)) mvec_hi   <= reg_wdata[DW-1:CODE_W];
        end
    end

    vpic_prio #(.N_SER(N_SER), .N_DMA(N_DMA), .N_TMR(N_TMR)) u_prio (
        .ser_m(m_ser), .dma_m(m_dma), .tmr_m(m_tmr),
        .dma_first(ctrl.dma_first), .code(code)
    );

    assign irq     = (|m_ser) | (|m_dma) | (|m_tmr);
    assign vec_sel = ctrl.vec_mod ? {mvec_hi, code} : fixed_vec;

    vpic_ack #(.VW(DW)) u_ack (
        .clk(clk), .rst(rst), .iack(iack), .mode(ctrl.mode),
        .vec_in(vec_sel), .vec_oe(vec_oe), .vec_out(vec_out)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            AW'(A_ST_SER): reg_rdata = DW'(st_ser);
            AW'(A_ST_DMA): reg_rdata = DW'(st_dma);
            AW'(A_ST_TMR): reg_rdata = DW'(st_tmr);
            AW'(A_EN_SER): reg_rdata = DW'(en_ser);
            AW'(A_EN_DMA): reg_rdata = DW'(en_dma);
            AW'(A_EN_TMR): reg_rdata = DW'(en_tmr);
            AW'(A_CTRL):   reg_rdata = DW'(ctrl);
            AW'(A_VEC):    reg_rdata = fixed_vec;
            AW'(A_MVEC):   reg_rdata = {mvec_hi, code};
            default:       reg_rdata = '0;
        endcase
    end

    // R3/R8: a request always has a real source code
    a_r3_irq_code: assert property (@(posedge clk) disable iff (rst)
        irq |-> (code != CODE_NONE));

    // R8: no request means the empty code
    a_r8_idle_code: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (code == CODE_NONE));

    // R9: timers never win over a pending serial or DMA source
    a_r9_timer_lowest: assert property (@(posedge clk) disable iff (rst)
        ((|m_ser) || (|m_dma)) |-> (int'(code) < TMR_BASE));
endmodule

// File: tb/vpic_top_test.sv
module vpic_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] src_ser = '0;
    logic [7:0] src_dma = '0;
    logic [3:0] src_tmr = '0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       iack = 1'b0;
    logic [7:0] vec_out;
    logic       vec_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vpic_top uut (
        .clk(clk), .rst(rst), .src_ser(src_ser), .src_dma(src_dma), .src_tmr(src_tmr),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .iack(iack), .vec_out(vec_out), .vec_oe(vec_oe)
    );

    // behavioural reference state
    bit [7:0] m_st[3];
    bit [7:0] m_en[3];
    bit [3:0] m_ctrl;
    bit [7:0] m_vec;
    bit [1:0] m_hi;
    bit       m_iq, m_pend2, m_oe;
    bit [7:0] m_vq;
    int       grp_w[3] = '{8, 8, 4};
    int       grp_base[3] = '{0, 8, 16};

    function automatic int m_code();
        int order[3];
        if (m_ctrl[3]) order = '{1, 0, 2}; else order = '{0, 1, 2};
        foreach (order[k]) begin
            int g = order[k];
            for (int i = 0; i < grp_w[g]; i++)
                if (m_st[g][i] && m_en[g][i]) return grp_base[g] + i;
        end
        return 63;
    endfunction

    function automatic bit [7:0] m_vector();
        if (m_ctrl[2]) return {m_hi, 6'(m_code())};
        return m_vec;
    endfunction

    function automatic bit [7:0] m_rd(input int a);
        case (a)
            0, 1, 2: return m_st[a];
            3, 4, 5: return m_en[a-3];
            6: return {4'b0, m_ctrl};
            7: return m_vec;
            8: return {m_hi, 6'(m_code())};
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit m_irq();
        for (int g = 0; g < 3; g++) if ((m_st[g] & m_en[g]) != 0) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < 3; g++) begin m_st[g] = 0; m_en[g] = 0; end
            m_ctrl = 0; m_vec = 0; m_hi = 0;
            m_iq = 0; m_pend2 = 0; m_oe = 0; m_vq = 0;
        end else begin
            bit [7:0] vnow;
            bit rise;
            bit [7:0] wmask;
            vnow = m_vector();
            rise = iack && !m_iq;
            if (!iack) m_oe = 0;
            if (rise) begin
                if (m_ctrl[1:0] == 2'b01) begin m_oe = 1; m_vq = vnow; end
                else if (m_ctrl[1:0] == 2'b10) begin
                    if (m_pend2) begin m_oe = 1; m_vq = vnow; m_pend2 = 0; end
                    else m_pend2 = 1;
                end
            end
            if (m_ctrl[1:0] != 2'b10) m_pend2 = 0;
            m_iq = iack;
            if (reg_wr) begin
                case (int'(reg_addr))
                    0, 1, 2: m_st[reg_addr] &= ~reg_wdata;
                    3, 4, 5: begin
                        wmask = (reg_addr == 5) ? 8'h0F : 8'hFF;
                        m_en[reg_addr-3] = reg_wdata & wmask;
                    end
                    6: m_ctrl = reg_wdata[3:0];
                    7: m_vec = reg_wdata;
                    8: m_hi = reg_wdata[7:6];
                    default: ;
                endcase
            end
            m_st[0] |= src_ser;
            m_st[1] |= src_dma;
            m_st[2] |= {4'b0, src_tmr};
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare away from the active edge, every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1/R2/R7/R8", "reg_rdata", int'(reg_rdata), int'(m_rd(int'(reg_addr))));
            chk("R3", "irq", int'(irq), int'(m_irq()));
            chk("R4/R5/R6", "vec_oe", int'(vec_oe), int'(m_oe));
            if (m_oe) chk("R7/R8/R9/R10", "vec_out", int'(vec_out), int'(m_vq));
        end
    end

    task automatic tick();
        @(posedge clk); #5;
    endtask

    task automatic wr(input int a, input int d);
        reg_addr = 4'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input int s, input int d, input int t);
        src_ser = 8'(s); src_dma = 8'(d); src_tmr = 4'(t);
        tick();
        src_ser = '0; src_dma = '0; src_tmr = '0;
    endtask

    task automatic ack(input int hold);
        iack = 1'b1;
        repeat (hold) tick();
        iack = 1'b0;
        tick(); tick();
    endtask

    task automatic look(input int a);
        reg_addr = 4'(a);
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1: reset state of every register
        for (int a = 0; a < 10; a++) look(a);

        // R1/R3: pulses set flags, enables gate irq
        pulse(8'h08, 8'h01, 0);
        look(0); look(1);
        wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 8'h0F);
        look(8);

        // R5/R7: single mode, fixed vector
        wr(7, 8'hA5); wr(6, 8'h01);
        ack(3);

        // R7/R8: modified vector carries serial 3 code
        wr(8, 8'hC0); wr(6, 8'h05);
        ack(2);
        // R9: swap lets DMA 0 win
        wr(6, 8'h0D);
        ack(2);

        // R2: clear and set on same bit in one cycle, set wins
        reg_addr = 4'd0; reg_wdata = 8'h08; reg_wr = 1'b1; src_ser = 8'h08;
        tick();
        reg_wr = 1'b0; src_ser = '0;
        look(0);
        // R2: writing zero leaves flags
        wr(1, 8'h00); look(1);
        wr(1, 8'h01); look(1);

        // R10: higher source arrives while vector is driven
        wr(6, 8'h05);
        iack = 1'b1; tick(); tick();
        pulse(8'h01, 0, 0);
        tick();
        iack = 1'b0; tick(); tick();

        // R6: double acknowledge
        wr(6, 8'h06);
        ack(2); ack(2); ack(2);
        // R4: reserved and none modes
        wr(6, 8'h07); ack(2);
        wr(6, 8'h04); ack(2);

        // R8/R9: timer only, then timer stays lowest under swap
        wr(0, 8'hFF); wr(1, 8'hFF);
        pulse(0, 0, 4'h4);
        wr(6, 8'h0D); ack(2);
        pulse(0, 8'h80, 0); ack(2);
        // R8: nothing enabled gives code 63
        wr(3, 0); wr(4, 0); wr(5, 0);
        ack(2); look(8);
        wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 8'h0F);

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            src_ser = 8'($urandom & $urandom & $urandom);
            src_dma = 8'($urandom & $urandom & $urandom);
            src_tmr = 4'($urandom & $urandom & $urandom);
            reg_addr = 4'($urandom_range(0, 9));
            reg_wdata = 8'($urandom);
            reg_wr = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 3) == 0) iack = ~iack;
            tick();
        end
        src_ser = '0; src_dma = '0; src_tmr = '0; reg_wr = 1'b0; iack = 1'b0;
        tick(); tick();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule